// File: doc/BRIEF.md
# Event-Driven Conversion-Start Prescaler

This block sits beside a PWM time base and turns the counter's zero and period strobes into start-of-conversion pulses for an analog sampler. It has two independent conversion-start channels, A and B, and a third channel that drives an interrupt request flag. Each channel has its own enable, a source select and a divide setting. The divide setting chooses whether the channel fires on the first, second or third qualifying strobe. Each channel's 2-bit event count is visible on an output port.

Every channel runs the same three-state machine. The states are `CH_OFF` (disabled), `CH_WAIT` (counting events) and `CH_FIRE` (the one-cycle pulse). The transitions are:
- any state to `CH_OFF` when the enable is low;
- `CH_OFF` or `CH_WAIT` to `CH_WAIT` when enabled and no terminal event occurs;
- any enabled state to `CH_FIRE` on the terminal event;
- `CH_FIRE` back to `CH_WAIT` when no new terminal event follows.

The interrupt flag has two states, `FLG_CLEAR` and `FLG_PEND`. The interrupt channel's pulse moves the flag from `FLG_CLEAR` to `FLG_PEND`. The clear input moves it from `FLG_PEND` back to `FLG_CLEAR`.

Top module: `et_trigger_unit`

## Requirements
- R1: After reset, `soc_a`, `soc_b` and `irq` are low and all three event counts are 0.
- R2: While a channel's enable is low, its pulse stays low and its count reads 0 one cycle later.
- R3: The source select is encoded as follows: 2'b00 = no source, 2'b01 = zero strobe, 2'b10 = period strobe, 2'b11 = either strobe. Under 2'b11, both strobes high in the same cycle count as a single event.
- R4: With a divide value N of 1, 2 or 3, the event count advances by one per qualifying event. On the Nth event, the channel's pulse is high for the single cycle after the clock edge that samples the event, and the count reads 0 in that same cycle.
- R5: With a divide value of 0, a channel never pulses. Its count advances per event and saturates at 3.
- R6: If a channel's source select or divide value differs from its value in the previous cycle, the count is cleared and that cycle's event is not counted. Both remembered values are 0 after reset.
- R7: Channels A and B count and fire independently of each other and of the interrupt channel.
- R8: The interrupt channel counts like the others, using its own enable, select and divide. `irq` rises one cycle after that channel's internal pulse and holds until `irq_clr`. If a pulse and a clear arrive together, the flag stays set.
- R9: An interrupt divide value of 0 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_stb | input | 1 | Time-base counter equals zero |
| prd_stb | input | 1 | Time-base counter equals period |
| a_en | input | 1 | Channel A enable |
| a_sel | input | 2 | Channel A source select |
| a_div | input | CNT_W | Channel A divide value |
| b_en | input | 1 | Channel B enable |
| b_sel | input | 2 | Channel B source select |
| b_div | input | CNT_W | Channel B divide value |
| i_en | input | 1 | Interrupt channel enable |
| i_sel | input | 2 | Interrupt channel source select |
| i_div | input | CNT_W | Interrupt channel divide value |
| irq_clr | input | 1 | Clears the interrupt flag |
| soc_a | output | 1 | Channel A conversion-start pulse |
| soc_b | output | 1 | Channel B conversion-start pulse |
| irq | output | 1 | Interrupt request flag |
| a_cnt | output | CNT_W | Channel A event count |
| b_cnt | output | CNT_W | Channel B event count |
| i_cnt | output | CNT_W | Interrupt channel event count |

## Verification
The count ports expose each machine's internal progress every cycle. A count that is stuck, skips a value, fails to saturate or survives a configuration change therefore shows up at the count port one cycle after the offending edge, before any pulse is due. A state machine that leaves `CH_FIRE` late or enters it early shows a pulse that is too wide or shifted by one cycle against the Nth event. A fault in the flag machine shows as `irq` rising a cycle off, or dropping without a clear.

// File: rtl/et_pkg.sv
package et_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_ZERO = 2'b01,
        SRC_PRD  = 2'b10,
        SRC_BOTH = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_FIRE = 2'd2
    } ch_state_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_PEND  = 1'b1
    } flg_state_e;

endpackage

// File: rtl/et_event_sel.sv
module et_event_sel
    import et_pkg::*;
(
    input  logic       zero_stb,
    input  logic       prd_stb,
    input  logic [1:0] sel,
    output logic       hit
);

    always_comb begin
        unique case (src_e'(sel))
            SRC_NONE: hit = 1'b0;
            SRC_ZERO: hit = zero_stb;
            SRC_PRD:  hit = prd_stb;
            SRC_BOTH: hit = zero_stb | prd_stb;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/et_channel.sv
module et_channel
    import et_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] div,
    input  logic             zero_stb,
    input  logic             prd_stb,
    output logic             pulse,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] div_q;
    logic             hit;
    logic             cfg_chg;
    logic             term;
    logic [CNT_W:0]   cnt_plus;

    et_event_sel u_sel (
        .zero_stb (zero_stb),
        .prd_stb  (prd_stb),
        .sel      (sel),
        .hit      (hit)
    );

    assign cfg_chg  = (sel != sel_q) || (div != div_q);
    assign cnt_plus = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign term     = en && !cfg_chg && hit && (div != '0) &&
                      (cnt_plus == {1'b0, div});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
            sel_q   <= '0;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel;
            div_q   <= div;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (!en)       state_d = CH_OFF;
                else if (term) state_d = CH_FIRE;
                else           state_d = CH_WAIT;
            end
            CH_WAIT: begin
                if (!en)       state_d = CH_OFF;
                else if (term) state_d = CH_FIRE;
                else           state_d = CH_WAIT;
            end
            CH_FIRE: begin
                if (!en)       state_d = CH_OFF;
                else if (term) state_d = CH_FIRE;
                else           state_d = CH_WAIT;
            end
            default: state_d = CH_OFF;
        endcase

        if (!en || cfg_chg || term) cnt_d = '0;
        else if (hit)              cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_plus[CNT_W-1:0];
        else                       cnt_d = cnt_q;
    end

    // outputs
    always_comb begin
        pulse = (state_q == CH_FIRE);
        cnt   = cnt_q;
    end

endmodule

// File: rtl/et_irq_flag.sv
module et_irq_flag
    import et_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    flg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: state_d = set ? FLG_PEND : FLG_CLEAR;
            FLG_PEND:  state_d = (clr && !set) ? FLG_CLEAR : FLG_PEND;
            default:   state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_PEND);
    end

endmodule

// File: rtl/et_trigger_unit.sv
module et_trigger_unit
    import et_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_stb,
    input  logic             prd_stb,
    input  logic             a_en,
    input  logic [1:0]       a_sel,
    input  logic [CNT_W-1:0] a_div,
    input  logic             b_en,
    input  logic [1:0]       b_sel,
    input  logic [CNT_W-1:0] b_div,
    input  logic             i_en,
    input  logic [1:0]       i_sel,
    input  logic [CNT_W-1:0] i_div,
    input  logic             irq_clr,
    output logic             soc_a,
    output logic             soc_b,
    output logic             irq,
    output logic [CNT_W-1:0] a_cnt,
    output logic [CNT_W-1:0] b_cnt,
    output logic [CNT_W-1:0] i_cnt
);

    localparam int NCH   = 3;
    localparam int CH_IR = NCH - 1;

    logic [NCH-1:0]   en_v;
    logic [NCH-1:0]   pulse_v;
    logic [1:0]       sel_v [NCH];
    logic [CNT_W-1:0] div_v [NCH];
    logic [CNT_W-1:0] cnt_v [NCH];

    assign en_v     = {i_en, b_en, a_en};
    assign sel_v[0] = a_sel;
    assign sel_v[1] = b_sel;
    assign sel_v[2] = i_sel;
    assign div_v[0] = a_div;
    assign div_v[1] = b_div;
    assign div_v[2] = i_div;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            et_channel #(.CNT_W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en_v[g]),
                .sel      (sel_v[g]),
                .div      (div_v[g]),
                .zero_stb (zero_stb),
                .prd_stb  (prd_stb),
                .pulse    (pulse_v[g]),
                .cnt      (cnt_v[g])
            );
        end
    endgenerate

    et_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pulse_v[CH_IR]),
        .clr   (irq_clr),
        .flag  (irq)
    );

    assign soc_a = pulse_v[0];
    assign soc_b = pulse_v[1];
    assign a_cnt = cnt_v[0];
    assign b_cnt = cnt_v[1];
    assign i_cnt = cnt_v[2];

endmodule

// File: rtl/et_trigger_checker.sv
module et_trigger_checker #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             zero_stb,
    input logic             prd_stb,
    input logic             a_en,
    input logic [1:0]       a_sel,
    input logic [CNT_W-1:0] a_div,
    input logic             b_en,
    input logic [CNT_W-1:0] b_div,
    input logic [CNT_W-1:0] i_div,
    input logic             irq_clr,
    input logic             soc_a,
    input logic             soc_b,
    input logic             irq,
    input logic [CNT_W-1:0] a_cnt,
    input logic [CNT_W-1:0] b_cnt
);

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> (!soc_a && a_cnt == '0));

    assert_b_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> !soc_b);

    assert_pulse_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soc_a |-> $past(zero_stb || prd_stb));

    assert_fire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soc_a |-> a_cnt == '0);

    assert_cnt_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a_div) != '0) |-> (a_cnt < $past(a_div)));

    assert_b_cnt_below_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(b_div) != '0) |-> (b_cnt < $past(b_div)));

    assert_cfg_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel != $past(a_sel) || a_div != $past(a_div)) |=> a_cnt == '0);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(i_div, 2) == '0) |-> !$rose(irq));

endmodule

bind et_trigger_unit et_trigger_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/et_trigger_unit_bench.sv
module et_trigger_unit_bench;

    localparam int TCK = 10;

    typedef struct {
        logic       soc_a;
        logic       soc_b;
        logic       irq;
        logic [1:0] a_cnt;
        logic [1:0] b_cnt;
        logic [1:0] i_cnt;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic zero_stb, prd_stb, irq_clr;
    logic a_en, b_en, i_en;
    logic [1:0] a_sel, b_sel, i_sel, a_div, b_div, i_div;
    logic soc_a, soc_b, irq;
    logic [1:0] a_cnt, b_cnt, i_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t sb[$];

    int m_cnt [3];
    int m_sel [3];
    int m_div [3];
    logic m_ipulse, m_flag;

    always #(TCK/2) clk = ~clk;

    et_trigger_unit u_et_trigger_unit (
        .clk(clk), .rst_n(rst_n), .zero_stb(zero_stb), .prd_stb(prd_stb),
        .a_en(a_en), .a_sel(a_sel), .a_div(a_div),
        .b_en(b_en), .b_sel(b_sel), .b_div(b_div),
        .i_en(i_en), .i_sel(i_sel), .i_div(i_div),
        .irq_clr(irq_clr), .soc_a(soc_a), .soc_b(soc_b), .irq(irq),
        .a_cnt(a_cnt), .b_cnt(b_cnt), .i_cnt(i_cnt)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // driver: apply one cycle of strobes and push the expected outputs
    task automatic step(input logic z, input logic p, input string tag);
        exp_t e;
        logic [2:0] term;
        zero_stb = z;
        prd_stb  = p;
        for (int c = 0; c < 3; c++) begin
            logic en;
            int s, d;
            logic hit;
            en  = (c == 0) ? a_en : (c == 1) ? b_en : i_en;
            s   = (c == 0) ? int'(a_sel) : (c == 1) ? int'(b_sel) : int'(i_sel);
            d   = (c == 0) ? int'(a_div) : (c == 1) ? int'(b_div) : int'(i_div);
            hit = (s == 1 && z) || (s == 2 && p) || (s == 3 && (z || p));
            term[c] = 1'b0;
            if (!en || s != m_sel[c] || d != m_div[c]) m_cnt[c] = 0;
            else if (hit) begin
                if (d != 0 && m_cnt[c] + 1 == d) begin
                    term[c] = 1'b1;
                    m_cnt[c] = 0;
                end else if (m_cnt[c] != 3) m_cnt[c]++;
            end
            m_sel[c] = s;
            m_div[c] = d;
        end
        e.irq    = m_ipulse ? 1'b1 : (irq_clr ? 1'b0 : m_flag);
        m_flag   = e.irq;
        m_ipulse = term[2];
        e.soc_a  = term[0];
        e.soc_b  = term[1];
        e.a_cnt  = 2'(m_cnt[0]);
        e.b_cnt  = 2'(m_cnt[1]);
        e.i_cnt  = 2'(m_cnt[2]);
        e.tag    = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare each cycle's outputs against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #(TCK/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "soc_a", int'(soc_a), int'(e.soc_a));
                check(e.tag, "soc_b", int'(soc_b), int'(e.soc_b));
                check(e.tag, "irq",   int'(irq),   int'(e.irq));
                check(e.tag, "a_cnt", int'(a_cnt), int'(e.a_cnt));
                check(e.tag, "b_cnt", int'(b_cnt), int'(e.b_cnt));
                check(e.tag, "i_cnt", int'(i_cnt), int'(e.i_cnt));
            end
        end
    end

    initial begin
        #(TCK * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; zero_stb = 1'b0; prd_stb = 1'b0; irq_clr = 1'b0;
        a_en = 1'b0; b_en = 1'b0; i_en = 1'b0;
        a_sel = 2'd0; b_sel = 2'd0; i_sel = 2'd0;
        a_div = 2'd0; b_div = 2'd0; i_div = 2'd0;
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 0; m_sel[c] = 0; m_div[c] = 0;
        end
        m_ipulse = 1'b0; m_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "soc_a", int'(soc_a), 0);
        check("R1", "soc_b", int'(soc_b), 0);
        check("R1", "irq",   int'(irq),   0);
        check("R1", "a_cnt", int'(a_cnt), 0);
        check("R1", "b_cnt", int'(b_cnt), 0);
        check("R1", "i_cnt", int'(i_cnt), 0);

        // R2 disabled channels ignore strobes
        step(1, 1, "R2"); step(1, 0, "R2"); step(0, 1, "R2");

        // R4 / R7: A zero div1, B period div2, I either div3
        a_en = 1; a_sel = 2'b01; a_div = 2'd1;
        b_en = 1; b_sel = 2'b10; b_div = 2'd2;
        i_en = 1; i_sel = 2'b11; i_div = 2'd3;
        step(1, 0, "R6");
        for (int k = 0; k < 4; k++) begin
            step(1, 0, "R4"); step(0, 0, "R4"); step(0, 1, "R7"); step(0, 0, "R8");
        end
        // R4 back-to-back events with divide 1
        step(1, 0, "R4"); step(1, 0, "R4"); step(1, 0, "R4");
        // R3 both strobes together count once
        step(1, 1, "R3"); step(1, 1, "R3"); step(0, 0, "R3"); step(1, 1, "R3");
        // R3 source none
        a_sel = 2'b00; step(1, 1, "R3"); step(1, 0, "R3"); step(0, 1, "R3");

        // R8 clear flag, then clear racing a set
        irq_clr = 1; step(0, 0, "R8"); irq_clr = 0; step(0, 0, "R8");
        step(1, 0, "R8"); step(0, 1, "R8"); step(1, 0, "R8");
        irq_clr = 1; step(0, 0, "R8"); step(0, 0, "R8"); irq_clr = 0; step(0, 0, "R8");

        // R5 divide 0 saturates
        a_sel = 2'b01; a_div = 2'd0;
        for (int k = 0; k < 6; k++) step(1, 0, "R5");

        // R6 change divide mid-count
        a_div = 2'd3; step(1, 0, "R6"); step(1, 0, "R6"); step(1, 0, "R6");
        a_div = 2'd2; step(1, 0, "R6"); step(1, 0, "R6"); step(1, 0, "R6");
        a_sel = 2'b11; step(1, 0, "R6"); step(0, 1, "R6"); step(0, 1, "R6");

        // R2 disable mid-count
        a_en = 0; step(1, 0, "R2"); step(1, 0, "R2");
        a_en = 1; step(1, 0, "R2"); step(1, 0, "R2"); step(1, 0, "R2");

        // R9 interrupt divide 0
        irq_clr = 1; step(0, 0, "R9"); irq_clr = 0;
        i_div = 2'd0;
        for (int k = 0; k < 8; k++) step(k[0], ~k[0], "R9");
        i_en = 0; i_div = 2'd1; step(1, 1, "R2"); step(1, 1, "R2"); step(0, 0, "R2");

        step(0, 0, "R7"); step(0, 0, "R7");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule